// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This block is the combinational hazard logic of a five-stage integer pipeline (fetch, decode, execute, memory, write-back). It reads the instruction words, class codes and valid bits of four pipeline registers: IF/ID, ID/EX, EX/MEM and MEM/WB. Register numbers are taken straight from fixed bit ranges of those words. Where each range lies depends on the instruction class.

From these inputs it drives one 2-bit bypass select for each of the two ALU operands of the instruction in ID/EX. Each select picks the register-file value, the EX/MEM ALU result or the MEM/WB write-back value. The block also raises a stall when a load sits in ID/EX and the instruction behind it in IF/ID reads the register being loaded. While the stall is high, the surrounding pipeline holds the PC and IF/ID and loads ID/EX with a bubble whose write enable is zero.

All outputs are combinational and respond in the same cycle as their inputs. Bit numbers below count from 0 at the most significant end of a 32-bit word, so bit k is vector index 31-k. Class codes are: 0 register-register ALU, 1 register-immediate ALU, 2 load, 3 store, 4 branch. Codes 5 to 7 neither read nor write registers.

Top module: `hz_forward_unit`

## Requirements
- R1: The operand-A select compares bits 6..10 of the ID/EX word with the producer destinations, and it uses the code 00 for the register file, 01 for the EX/MEM ALU output and 10 for the MEM/WB write-back value; code 11 never appears.
- R2: Operand A is a read for classes 0 to 4. Operand B (bits 11..15 of the ID/EX word) is a read only for class 0 and class 3. A field that is not read always gets the select 00.
- R3: A producer's destination is bits 16..20 for class 0, and bits 11..15 for class 1 and class 2. Classes 3 to 7 have no destination.
- R4: When a valid class 0 or class 1 instruction in EX/MEM has a destination equal to a read source field, that operand gets the select 01 in the same cycle, and no stall is raised.
- R5: When a valid class 0, 1 or 2 instruction in MEM/WB has a destination equal to a read source field, and EX/MEM does not qualify for that field, the operand gets the select 10.
- R6: When both EX/MEM and MEM/WB qualify for the same field, EX/MEM wins and the select is 01.
- R7: A destination of register 0 is never forwarded and never causes a stall.
- R8: A producer whose valid bit is low is ignored. When the ID/EX valid bit is low, both selects are 00.
- R9: A load in EX/MEM never gives the select 01. That field falls through to the MEM/WB match or to 00.
- R10: The stall is high exactly when a valid load in ID/EX has a nonzero destination that equals a field read by the valid instruction in IF/ID (read rules as in R2). A non-load producer in ID/EX never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_instr | input | 32 | Instruction word in IF/ID |
| ifid_cls | input | 3 | Class code of the IF/ID instruction |
| ifid_vld | input | 1 | IF/ID holds a real instruction |
| idex_instr | input | 32 | Instruction word in ID/EX |
| idex_cls | input | 3 | Class code of the ID/EX instruction |
| idex_vld | input | 1 | ID/EX holds a real instruction |
| exmem_instr | input | 32 | Instruction word in EX/MEM |
| exmem_cls | input | 3 | Class code of the EX/MEM instruction |
| exmem_vld | input | 1 | EX/MEM holds a real instruction |
| memwb_instr | input | 32 | Instruction word in MEM/WB |
| memwb_cls | input | 3 | Class code of the MEM/WB instruction |
| memwb_vld | input | 1 | MEM/WB holds a real instruction |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B |
| load_stall | output | 1 | Hold PC and IF/ID, and insert a bubble into ID/EX |

## Verification
The embedded checks assume that every valid bit and class code is driven to a known value each cycle, and that a word whose valid bit is low may carry any bits at all. The stimulus respects this by driving every input on each cycle. It keeps register numbers in a small range so that field matches are frequent. It also deliberately pairs invalid stages, unused class codes 5 to 7 and register-0 destinations with words that would otherwise match.

// File: rtl/hz_pkg.sv
package hz_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_RR     = 3'd0,
      CLS_RI     = 3'd1,
      CLS_LOAD   = 3'd2,
      CLS_STORE  = 3'd3,
      CLS_BRANCH = 3'd4
   } op_cls_e;

   typedef enum logic [1:0] {
      SEL_RF    = 2'b00,
      SEL_EXMEM = 2'b01,
      SEL_MEMWB = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_dest_decode.sv
module hz_dest_decode
   import hz_pkg::*;
#(
   parameter int IW             = 32,
   parameter int RW             = 5,
   parameter int SRC2_POS       = 11,
   parameter int RRDST_POS      = 16,
   parameter bit ZERO_REG_CONST = 1'b1
) (
   input  logic [IW-1:0]    instr,
   input  logic [CLS_W-1:0] cls,
   input  logic             vld,
   output logic [RW-1:0]    dst,
   output logic             wr
);
   localparam int RI_LO = IW - SRC2_POS - RW;
   localparam int RR_LO = IW - RRDST_POS - RW;

   logic writes;
   logic nonzero;

   always_comb begin
      dst    = '0;
      writes = 1'b0;
      case (cls)
         CLS_RR: begin
            dst    = instr[RR_LO +: RW];
            writes = 1'b1;
         end
         CLS_RI, CLS_LOAD: begin
            dst    = instr[RI_LO +: RW];
            writes = 1'b1;
         end
         default: begin
            dst    = '0;
            writes = 1'b0;
         end
      endcase
   end

   generate
      if (ZERO_REG_CONST) begin : g_zero_const
         assign nonzero = |dst;
      end else begin : g_zero_plain
         assign nonzero = 1'b1;
      end
   endgenerate

   assign wr = vld & writes & nonzero;

   always_comb begin
      if (wr && ZERO_REG_CONST)
         p_wr_nonzero_r7: assert (dst != '0);
      if (wr)
         p_wr_class_r3: assert (cls == CLS_RR || cls == CLS_RI || cls == CLS_LOAD);
   end
endmodule

// File: rtl/hz_src_decode.sv
module hz_src_decode
   import hz_pkg::*;
#(
   parameter int IW       = 32,
   parameter int RW       = 5,
   parameter int SRC1_POS = 6,
   parameter int SRC2_POS = 11
) (
   input  logic [IW-1:0]    instr,
   input  logic [CLS_W-1:0] cls,
   input  logic             vld,
   output logic [RW-1:0]    src1,
   output logic [RW-1:0]    src2,
   output logic             rd1,
   output logic             rd2
);
   localparam int S1_LO = IW - SRC1_POS - RW;
   localparam int S2_LO = IW - SRC2_POS - RW;

   logic use1;
   logic use2;

   assign src1 = instr[S1_LO +: RW];
   assign src2 = instr[S2_LO +: RW];

   always_comb begin
      case (cls)
         CLS_RR, CLS_STORE: begin
            use1 = 1'b1;
            use2 = 1'b1;
         end
         CLS_RI, CLS_LOAD, CLS_BRANCH: begin
            use1 = 1'b1;
            use2 = 1'b0;
         end
         default: begin
            use1 = 1'b0;
            use2 = 1'b0;
         end
      endcase
   end

   assign rd1 = vld & use1;
   assign rd2 = vld & use2;

   always_comb begin
      if (rd2)
         p_rd2_implies_rd1_r2: assert (rd1);
   end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
   import hz_pkg::*;
#(
   parameter int RW = 5
) (
   input  logic [RW-1:0] src,
   input  logic          used,
   input  logic [RW-1:0] ex_dst,
   input  logic          ex_ok,
   input  logic [RW-1:0] wb_dst,
   input  logic          wb_ok,
   output fwd_sel_e      sel
);
   logic ex_hit;
   logic wb_hit;

   assign ex_hit = used & ex_ok & (ex_dst == src);
   assign wb_hit = used & wb_ok & (wb_dst == src);

   always_comb begin
      if (ex_hit)
         sel = SEL_EXMEM;
      else if (wb_hit)
         sel = SEL_MEMWB;
      else
         sel = SEL_RF;
   end

   always_comb begin
      p_sel_code_r1: assert (sel != 2'b11);
      if (sel == SEL_MEMWB)
         p_older_loses_r6: assert (!(ex_ok && ex_dst == src));
      if (!used)
         p_unread_rf_r2: assert (sel == SEL_RF);
   end
endmodule

// File: rtl/hz_load_interlock.sv
module hz_load_interlock #(
   parameter int RW = 5
) (
   input  logic          ld_act,
   input  logic [RW-1:0] ld_dst,
   input  logic [RW-1:0] c_src1,
   input  logic          c_rd1,
   input  logic [RW-1:0] c_src2,
   input  logic          c_rd2,
   output logic          stall
);
   logic hit1;
   logic hit2;

   assign hit1  = c_rd1 & (c_src1 == ld_dst);
   assign hit2  = c_rd2 & (c_src2 == ld_dst);
   assign stall = ld_act & (hit1 | hit2);

   always_comb begin
      if (stall)
         p_stall_needs_reader_r10: assert (c_rd1 || c_rd2);
   end
endmodule

// File: rtl/hz_forward_unit.sv
module hz_forward_unit
   import hz_pkg::*;
#(
   parameter int IW             = 32,
   parameter int RW             = 5,
   parameter int SRC1_POS       = 6,
   parameter int SRC2_POS       = 11,
   parameter int RRDST_POS      = 16,
   parameter bit ZERO_REG_CONST = 1'b1
) (
   input  logic [IW-1:0]    ifid_instr,
   input  logic [CLS_W-1:0] ifid_cls,
   input  logic             ifid_vld,
   input  logic [IW-1:0]    idex_instr,
   input  logic [CLS_W-1:0] idex_cls,
   input  logic             idex_vld,
   input  logic [IW-1:0]    exmem_instr,
   input  logic [CLS_W-1:0] exmem_cls,
   input  logic             exmem_vld,
   input  logic [IW-1:0]    memwb_instr,
   input  logic [CLS_W-1:0] memwb_cls,
   input  logic             memwb_vld,
   output logic [1:0]       fwd_a_sel,
   output logic [1:0]       fwd_b_sel,
   output logic             load_stall
);
   localparam int N_PROD = 3;   // ID/EX, EX/MEM, MEM/WB
   localparam int N_READ = 2;   // IF/ID, ID/EX
   localparam int N_OPS  = 2;
   localparam int P_IDEX = 0, P_EXMEM = 1, P_MEMWB = 2;
   localparam int Q_IFID = 0, Q_IDEX = 1;
   localparam int A_LO   = IW - SRC1_POS - RW;
   localparam int B_LO   = IW - SRC2_POS - RW;

   generate
      if (SRC1_POS + RW > IW || SRC2_POS + RW > IW || RRDST_POS + RW > IW)
         $error("hz_forward_unit: a register field lies outside the word");
      if (SRC1_POS == SRC2_POS)
         $error("hz_forward_unit: source fields overlap");
      if (RW < 1)
         $error("hz_forward_unit: register width must be positive");
   endgenerate

   logic [IW-1:0]    p_instr [N_PROD];
   logic [CLS_W-1:0] p_cls   [N_PROD];
   logic             p_vld   [N_PROD];
   logic [RW-1:0]    p_dst   [N_PROD];
   logic             p_wr    [N_PROD];

   logic [IW-1:0]    q_instr [N_READ];
   logic [CLS_W-1:0] q_cls   [N_READ];
   logic             q_vld   [N_READ];
   logic [RW-1:0]    q_src1  [N_READ];
   logic [RW-1:0]    q_src2  [N_READ];
   logic             q_rd1   [N_READ];
   logic             q_rd2   [N_READ];

   assign p_instr[P_IDEX]  = idex_instr;
   assign p_cls[P_IDEX]    = idex_cls;
   assign p_vld[P_IDEX]    = idex_vld;
   assign p_instr[P_EXMEM] = exmem_instr;
   assign p_cls[P_EXMEM]   = exmem_cls;
   assign p_vld[P_EXMEM]   = exmem_vld;
   assign p_instr[P_MEMWB] = memwb_instr;
   assign p_cls[P_MEMWB]   = memwb_cls;
   assign p_vld[P_MEMWB]   = memwb_vld;

   assign q_instr[Q_IFID] = ifid_instr;
   assign q_cls[Q_IFID]   = ifid_cls;
   assign q_vld[Q_IFID]   = ifid_vld;
   assign q_instr[Q_IDEX] = idex_instr;
   assign q_cls[Q_IDEX]   = idex_cls;
   assign q_vld[Q_IDEX]   = idex_vld;

   genvar g;
   generate
      for (g = 0; g < N_PROD; g++) begin : g_prod
         hz_dest_decode #(
            .IW(IW), .RW(RW), .SRC2_POS(SRC2_POS),
            .RRDST_POS(RRDST_POS), .ZERO_REG_CONST(ZERO_REG_CONST)
         ) i_dest (
            .instr(p_instr[g]), .cls(p_cls[g]), .vld(p_vld[g]),
            .dst(p_dst[g]), .wr(p_wr[g])
         );
      end
      for (g = 0; g < N_READ; g++) begin : g_read
         hz_src_decode #(
            .IW(IW), .RW(RW), .SRC1_POS(SRC1_POS), .SRC2_POS(SRC2_POS)
         ) i_src (
            .instr(q_instr[g]), .cls(q_cls[g]), .vld(q_vld[g]),
            .src1(q_src1[g]), .src2(q_src2[g]),
            .rd1(q_rd1[g]), .rd2(q_rd2[g])
         );
      end
   endgenerate

   // EX/MEM holds an address, not data, for a load: it may not bypass.
   logic ex_ok;
   logic ld_act;
   assign ex_ok  = p_wr[P_EXMEM] & (exmem_cls != CLS_LOAD);
   assign ld_act = p_wr[P_IDEX] & (idex_cls == CLS_LOAD);

   logic [RW-1:0] op_src  [N_OPS];
   logic          op_used [N_OPS];
   fwd_sel_e      op_sel  [N_OPS];

   assign op_src[0]  = q_src1[Q_IDEX];
   assign op_used[0] = q_rd1[Q_IDEX];
   assign op_src[1]  = q_src2[Q_IDEX];
   assign op_used[1] = q_rd2[Q_IDEX];

   generate
      for (g = 0; g < N_OPS; g++) begin : g_op
         hz_fwd_pick #(.RW(RW)) i_pick (
            .src(op_src[g]), .used(op_used[g]),
            .ex_dst(p_dst[P_EXMEM]), .ex_ok(ex_ok),
            .wb_dst(p_dst[P_MEMWB]), .wb_ok(p_wr[P_MEMWB]),
            .sel(op_sel[g])
         );
      end
   endgenerate

   hz_load_interlock #(.RW(RW)) i_lock (
      .ld_act(ld_act), .ld_dst(p_dst[P_IDEX]),
      .c_src1(q_src1[Q_IFID]), .c_rd1(q_rd1[Q_IFID]),
      .c_src2(q_src2[Q_IFID]), .c_rd2(q_rd2[Q_IFID]),
      .stall(load_stall)
   );

   assign fwd_a_sel = op_sel[0];
   assign fwd_b_sel = op_sel[1];

   always_comb begin
      if (!idex_vld)
         p_idle_rf_r8: assert (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00);
      if (fwd_a_sel == 2'b01 || fwd_b_sel == 2'b01)
         p_ex_src_alu_r9: assert (exmem_vld && (exmem_cls == CLS_RR || exmem_cls == CLS_RI));
      if (fwd_a_sel == 2'b10 || fwd_b_sel == 2'b10)
         p_wb_src_ok_r5: assert (memwb_vld && (memwb_cls == CLS_RR || memwb_cls == CLS_RI
                                                || memwb_cls == CLS_LOAD));
      if (fwd_a_sel != 2'b00 && ZERO_REG_CONST)
         p_a_not_zero_r7: assert (idex_instr[A_LO +: RW] != '0);
      if (fwd_b_sel != 2'b00 && ZERO_REG_CONST)
         p_b_not_zero_r7: assert (idex_instr[B_LO +: RW] != '0);
      if (load_stall)
         p_stall_by_load_r10: assert (idex_vld && idex_cls == CLS_LOAD && ifid_vld);
   end
endmodule

// File: tb/test_hz_forward_unit.sv
module test_hz_forward_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        run = 1'b0;
   int          checks = 0;
   int          failures = 0;
   string       tag = "R8";

   logic [31:0] ifid_instr = '0, idex_instr = '0, exmem_instr = '0, memwb_instr = '0;
   logic [2:0]  ifid_cls = '0, idex_cls = '0, exmem_cls = '0, memwb_cls = '0;
   logic        ifid_vld = 1'b0, idex_vld = 1'b0, exmem_vld = 1'b0, memwb_vld = 1'b0;
   logic [1:0]  fwd_a_sel, fwd_b_sel;
   logic        load_stall;

   always #10 clk = ~clk;   // 50 MHz

   hz_forward_unit i_hz_forward_unit (
      .ifid_instr(ifid_instr), .ifid_cls(ifid_cls), .ifid_vld(ifid_vld),
      .idex_instr(idex_instr), .idex_cls(idex_cls), .idex_vld(idex_vld),
      .exmem_instr(exmem_instr), .exmem_cls(exmem_cls), .exmem_vld(exmem_vld),
      .memwb_instr(memwb_instr), .memwb_cls(memwb_cls), .memwb_vld(memwb_vld),
      .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .load_stall(load_stall)
   );

   // Field at bits pos..pos+4, bit 0 being the MSB.
   function automatic int fld(logic [31:0] w, int pos);
      return int'((w >> (27 - pos)) & 32'h1f);
   endfunction

   function automatic logic [31:0] mk(int s1, int s2, int d);
      logic [31:0] w;
      w = 32'hA400_07FF & $urandom;
      w = w | (32'(s1) << 21) | (32'(s2) << 16) | (32'(d) << 11);
      return w;
   endfunction

   function automatic int dest_of(logic [31:0] w, logic [2:0] c, logic v);
      if (!v) return 0;
      if (c == 3'd0) return fld(w, 16);
      if (c == 3'd1 || c == 3'd2) return fld(w, 11);
      return 0;
   endfunction

   function automatic bit reads_a(logic [2:0] c); return c <= 3'd4; endfunction
   function automatic bit reads_b(logic [2:0] c); return c == 3'd0 || c == 3'd3; endfunction

   function automatic int model_sel(int src, bit used);
      int exd, wbd;
      exd = (exmem_cls == 3'd2) ? 0 : dest_of(exmem_instr, exmem_cls, exmem_vld);
      wbd = dest_of(memwb_instr, memwb_cls, memwb_vld);
      if (!used || src == 0) return 0;
      if (exd != 0 && exd == src) return 1;
      if (wbd != 0 && wbd == src) return 2;
      return 0;
   endfunction

   function automatic int model_stall();
      int ld;
      ld = (idex_vld && idex_cls == 3'd2) ? fld(idex_instr, 11) : 0;
      if (ld == 0 || !ifid_vld) return 0;
      if (reads_a(ifid_cls) && fld(ifid_instr, 6) == ld) return 1;
      if (reads_b(ifid_cls) && fld(ifid_instr, 11) == ld) return 1;
      return 0;
   endfunction

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Compared on every clock, away from the edge where inputs change.
   always @(negedge clk) begin
      if (run && !rst) begin
         chk("fwd_a_sel", int'(fwd_a_sel),
             idex_vld ? model_sel(fld(idex_instr, 6), reads_a(idex_cls)) : 0);
         chk("fwd_b_sel", int'(fwd_b_sel),
             idex_vld ? model_sel(fld(idex_instr, 11), reads_b(idex_cls)) : 0);
         chk("load_stall", int'(load_stall), model_stall());
      end
   end

   task automatic put(string t,
                      logic [31:0] fi, logic [2:0] fc, logic fv,
                      logic [31:0] di, logic [2:0] dc, logic dv,
                      logic [31:0] ei, logic [2:0] ec, logic ev,
                      logic [31:0] wi, logic [2:0] wc, logic wv);
      @(posedge clk);
      tag = t;
      ifid_instr = fi; ifid_cls = fc; ifid_vld = fv;
      idex_instr = di; idex_cls = dc; idex_vld = dv;
      exmem_instr = ei; exmem_cls = ec; exmem_vld = ev;
      memwb_instr = wi; memwb_cls = wc; memwb_vld = wv;
   endtask

   task automatic direct(string t, int ea, int eb, int es);
      @(negedge clk);
      chk({t, " direct a"}, int'(fwd_a_sel), ea);
      chk({t, " direct b"}, int'(fwd_b_sel), eb);
      chk({t, " direct stall"}, int'(load_stall), es);
   endtask

   initial begin : watchdog
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      run = 1'b1;
      // R8: reset-like state, everything invalid
      put("R8", mk(1,1,1),0,0, mk(1,1,1),0,0, mk(0,0,1),0,0, mk(0,0,1),0,0);
      direct("R8", 0, 0, 0);
      // R1 R4: add then sub reading its destination -> 01, no stall
      put("R1_R4", mk(0,0,0),7,1, mk(3,4,9),0,1, mk(1,2,3),0,1, mk(0,0,0),5,1);
      direct("R4", 1, 0, 0);
      // R5 R2: operand B from MEM/WB
      put("R5_R2", mk(0,0,0),7,1, mk(6,4,9),0,1, mk(1,2,3),0,1, mk(1,2,4),0,1);
      direct("R5", 0, 2, 0);
      // R6: both stages write register 5
      put("R6", mk(0,0,0),7,0, mk(5,5,9),0,1, mk(1,2,5),0,1, mk(1,2,5),0,1);
      direct("R6", 1, 1, 0);
      // R7: register 0 destination
      put("R7", mk(0,0,0),7,0, mk(0,0,9),0,1, mk(1,2,0),0,1, mk(1,0,9),1,1);
      direct("R7", 0, 0, 0);
      // R3: store and branch never produce; RI produces from bits 11..15
      put("R3", mk(0,0,0),7,0, mk(8,10,9),0,1, mk(1,2,8),3,1, mk(1,10,8),1,1);
      direct("R3", 0, 2, 0);
      put("R3", mk(0,0,0),7,0, mk(8,10,9),0,1, mk(1,8,2),1,1, mk(1,2,10),4,1);
      direct("R3", 1, 0, 0);
      // R9: load in EX/MEM does not bypass; load in MEM/WB does
      put("R9", mk(0,0,0),7,0, mk(12,13,9),0,1, mk(1,12,0),2,1, mk(1,13,0),2,1);
      direct("R9", 0, 2, 0);
      put("R9", mk(0,0,0),7,0, mk(12,13,9),0,1, mk(1,12,0),2,1, mk(1,12,0),0,0);
      direct("R9", 0, 0, 0);
      // R2: RI consumer does not read field 11..15; class 6 reads nothing
      put("R2", mk(0,0,0),7,0, mk(14,3,0),1,1, mk(1,2,3),0,1, mk(0,0,0),7,1);
      direct("R2", 0, 0, 0);
      put("R2", mk(0,0,0),7,0, mk(3,3,0),6,1, mk(1,2,3),0,1, mk(0,0,0),7,1);
      direct("R2", 0, 0, 0);
      // R8: invalid producers ignored
      put("R8", mk(0,0,0),7,0, mk(3,4,0),0,1, mk(1,2,3),0,0, mk(1,2,4),0,0);
      direct("R8", 0, 0, 0);
      // R10: load-use stall on operand A, then on B of a store
      put("R10", mk(7,1,1),0,1, mk(2,7,0),2,1, mk(0,0,0),7,0, mk(0,0,0),7,0);
      direct("R10", 0, 0, 1);
      put("R10", mk(1,7,1),3,1, mk(2,7,0),2,1, mk(0,0,0),7,0, mk(0,0,0),7,0);
      direct("R10", 0, 0, 1);
      // R10: RI consumer's bits 11..15 are its destination, not a read
      put("R10", mk(1,7,1),1,1, mk(2,7,0),2,1, mk(0,0,0),7,0, mk(0,0,0),7,0);
      direct("R10", 0, 0, 0);
      // R10: RR producer in ID/EX never stalls; invalid consumer never stalls
      put("R10", mk(7,1,1),0,1, mk(2,3,7),0,1, mk(0,0,0),7,0, mk(0,0,0),7,0);
      direct("R10", 0, 0, 0);
      put("R10", mk(7,1,1),0,0, mk(2,7,0),2,1, mk(0,0,0),7,0, mk(0,0,0),7,0);
      direct("R10", 0, 0, 0);
      // R7: load to register 0 never stalls
      put("R7", mk(0,1,1),0,1, mk(2,0,0),2,1, mk(0,0,0),7,0, mk(0,0,0),7,0);
      direct("R7", 0, 0, 0);
      // R1 R4 R5 R6 R10: random mix over registers 0..3
      for (int i = 0; i < 2000; i++) begin
         put("R1_R4_R5_R6_R10",
             mk($urandom%4, $urandom%4, $urandom%4), 3'($urandom), 1'($urandom),
             mk($urandom%4, $urandom%4, $urandom%4), 3'($urandom), 1'($urandom),
             mk($urandom%4, $urandom%4, $urandom%4), 3'($urandom), 1'($urandom),
             mk($urandom%4, $urandom%4, $urandom%4), 3'($urandom), 1'($urandom));
      end
      @(posedge clk);
      @(negedge clk);
      run = 1'b0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule